// File: doc/BRIEF.md
# Hardware Exception Cause Encoder

This block sits beside a processor's execute stage and gathers four kinds of fault: an integer divide by zero, a misaligned data access, a stack access outside its permitted window, and an access to an unassigned address on the instruction or data bus. Each source arrives as a one-cycle strobe together with the operands needed to judge it. The block decides whether the event is a fault, picks one winner when several fire together, and updates an exception status register (cause code, access direction, word-size flag, destination register), an exception address register, and a sticky divide-by-zero status flag.

A single-cycle exception request goes out on the clock edge that samples the strobe. The status and address registers keep their contents until a later event updates them. Each source has its own gating: a global exceptions-enabled input and, for the divide and the two bus kinds, a configuration bit. A combinational squash output tells the divider in the same cycle to force its quotient to zero. The divider itself and the jump to a handler live elsewhere.

Top module: `exc_cause_encoder`

## Requirements
- R1: While reset is held at a clock edge, `esr`, `ear`, `msr_dz` and `exc_req` all become 0.
- R2: A divide strobe with divisor 0 sets `msr_dz` at the next edge, and a divide strobe with a nonzero divisor clears it. `div_squash` is high in the same cycle exactly when the strobe is present with divisor 0.
- R3: A divide by zero updates `esr` to cause code 5 (bits 4:0, all other bits 0) and pulses `exc_req`, leaving `ear` untouched. This happens only when `exc_en` is 1 and `cfg_divz_mask` is 0. Otherwise it changes neither register and raises no request.
- R4: An access is misaligned when `acc_addr` AND `acc_mask` (low mask bits) is nonzero. On a misaligned access `ear` takes `acc_addr` and `esr` takes cause 1 in bits 4:0, `acc_dreg` in bits 9:5, `acc_write` in bit 10, and in bit 11 a 1 when the mask is all ones (3, a word access). An aligned access changes nothing.
- R5: A misaligned access records `esr` and `ear` whatever `exc_en` is, but pulses `exc_req` only when `exc_en` is 1.
- R6: A stack access with `stk_addr` below `stk_low` or above `stk_high` (unsigned, both limits inclusive-legal) writes `ear` with the address and `esr` with cause 7, and pulses `exc_req`, regardless of `exc_en`. An address inside the window changes nothing.
- R7: A bus error with `exc_en` 0 has no effect at all. With `exc_en` 1, `ear` takes `bus_addr`. If `bus_fetch` is 1 and `cfg_ibus_en` is 1, `esr` becomes cause 3 and `exc_req` pulses. If `bus_fetch` is 0 and `cfg_dbus_en` is 1, `esr` becomes cause 4 and `exc_req` pulses. Otherwise `esr` is kept and no request is made.
- R8: When several sources would act in the same cycle, only the highest-ranked one updates `esr`/`ear` and decides `exc_req`. The ranking is stack, then misalignment, then divide by zero, then bus error.
- R9: `exc_req` is high for one cycle per sampled event. In a cycle with no strobe, `esr` and `ear` hold and no request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_en | input | 1 | Global exceptions-enabled bit |
| cfg_divz_mask | input | 1 | 1 masks the divide-by-zero exception |
| cfg_ibus_en | input | 1 | Enables instruction-bus error exceptions |
| cfg_dbus_en | input | 1 | Enables data-bus error exceptions |
| div_valid | input | 1 | Divide issue strobe |
| div_divisor | input | DATA_W | Divisor operand |
| acc_valid | input | 1 | Data access strobe for the alignment check |
| acc_addr | input | ADDR_W | Access address |
| acc_mask | input | MASK_W | Alignment mask (3 = word, 1 = halfword) |
| acc_write | input | 1 | 1 for a store |
| acc_dreg | input | REG_W | Destination/source register number |
| stk_valid | input | 1 | Stack access strobe |
| stk_addr | input | ADDR_W | Stack access address |
| stk_low | input | ADDR_W | Lowest legal stack address |
| stk_high | input | ADDR_W | Highest legal stack address |
| bus_err | input | 1 | Unassigned-address strobe |
| bus_fetch | input | 1 | 1 when the faulting access was a fetch |
| bus_addr | input | ADDR_W | Faulting bus address |
| div_squash | output | 1 | Force quotient to zero (combinational) |
| esr | output | ESR_W | Exception status register |
| ear | output | ADDR_W | Exception address register |
| msr_dz | output | 1 | Sticky divide-by-zero status flag |
| exc_req | output | 1 | One-cycle exception request |

## Verification
Any of the four sources can fire in the same cycle as another, and the case that matters most is a divide by zero together with a bus error. Both would write the status register, but only the bus error would write the address register. The bench strobes both in one cycle with exceptions enabled. It then checks that the divide cause appears while the address register keeps its earlier value. It also drives all four sources at once and then three without the stack, and judges the recorded cause, address and request against the fixed ranking.

// File: rtl/exc_pkg.sv
// Shared cause codes and per-source control record for the exception encoder.
package exc_pkg;

    localparam int CAUSE_W = 5;

    // Cause codes written to the low status bits.
    typedef enum logic [CAUSE_W-1:0] {
        EC_NONE      = 5'd0,
        EC_UNALIGNED = 5'd1,
        EC_IBUS      = 5'd3,
        EC_DBUS      = 5'd4,
        EC_DIVZ      = 5'd5,
        EC_STACK     = 5'd7
    } exc_cause_e;

    // What one source wants to do this cycle.
    typedef struct packed {
        logic touch;   // source claims the registers (takes part in ranking)
        logic esr_wr;  // status register is written
        logic ear_wr;  // address register is written
        logic raise;   // exception request is made
    } exc_ctl_t;

endpackage

// File: rtl/exc_div_chk.sv
// Divide-by-zero evaluator.
// Holds the sticky divide-by-zero status flag and reports a claim when the
// fault must be recorded. Assumes one divide strobe per cycle at most.
module exc_div_chk
    import exc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ESR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_valid,
    input  logic [DATA_W-1:0] divisor,
    input  logic              exc_en,
    input  logic              cfg_divz_mask,
    output logic              squash,
    output logic              msr_dz,
    output exc_ctl_t          ctl,
    output logic [ESR_W-1:0]  esr_val
);

    logic zero_div;

    // Detect a divide whose divisor is zero.
    always_comb begin
        zero_div = div_valid && (divisor == '0);
        squash   = zero_div;
    end

    // Claim the registers only when the fault may raise an exception.
    always_comb begin
        ctl.touch  = zero_div && exc_en && !cfg_divz_mask;
        ctl.esr_wr = ctl.touch;
        ctl.ear_wr = 1'b0;
        ctl.raise  = ctl.touch;
        esr_val    = ESR_W'(EC_DIVZ);
    end

    // Sticky flag: set on a zero divisor, cleared on any other divide.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msr_dz <= 1'b0;
        end else if (div_valid) begin
            msr_dz <= (divisor == '0);
        end
    end

    assert_dz_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (div_valid && divisor == '0) |=> msr_dz);

    assert_dz_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (div_valid && divisor != '0) |=> !msr_dz);

endmodule

// File: rtl/exc_mem_chk.sv
// Memory-side evaluators: data alignment check and stack window check.
// Both are combinational; the window limits are unsigned and legal when equal.
module exc_mem_chk
    import exc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MASK_W = 2,
    parameter int REG_W  = 5,
    parameter int ESR_W  = 32
) (
    input  logic              exc_en,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [MASK_W-1:0] acc_mask,
    input  logic              acc_write,
    input  logic [REG_W-1:0]  acc_dreg,
    input  logic              stk_valid,
    input  logic [ADDR_W-1:0] stk_addr,
    input  logic [ADDR_W-1:0] stk_low,
    input  logic [ADDR_W-1:0] stk_high,
    output exc_ctl_t          al_ctl,
    output logic [ESR_W-1:0]  al_esr,
    output logic [ADDR_W-1:0] al_ear,
    output exc_ctl_t          st_ctl,
    output logic [ESR_W-1:0]  st_esr,
    output logic [ADDR_W-1:0] st_ear
);

    localparam int DREG_LSB = CAUSE_W;
    localparam int WR_BIT   = DREG_LSB + REG_W;
    localparam int WORD_BIT = WR_BIT + 1;

    logic misaligned;
    logic word_acc;
    logic out_of_window;

    // Alignment: record always, raise only with exceptions enabled.
    always_comb begin
        misaligned     = acc_valid && |(acc_addr[MASK_W-1:0] & acc_mask);
        word_acc       = &acc_mask;
        al_ctl.touch   = misaligned;
        al_ctl.esr_wr  = misaligned;
        al_ctl.ear_wr  = misaligned;
        al_ctl.raise   = misaligned && exc_en;
        al_esr         = '0;
        al_esr[CAUSE_W-1:0]          = EC_UNALIGNED;
        al_esr[WR_BIT-1:DREG_LSB]    = acc_dreg;
        al_esr[WR_BIT]               = acc_write;
        al_esr[WORD_BIT]             = word_acc;
        al_ear         = acc_addr;
    end

    // Stack window: any access outside [low, high] faults unconditionally.
    always_comb begin
        out_of_window  = stk_valid && ((stk_addr < stk_low) || (stk_addr > stk_high));
        st_ctl.touch   = out_of_window;
        st_ctl.esr_wr  = out_of_window;
        st_ctl.ear_wr  = out_of_window;
        st_ctl.raise   = out_of_window;
        st_esr         = ESR_W'(EC_STACK);
        st_ear         = stk_addr;
    end

endmodule

// File: rtl/exc_bus_chk.sv
// Unassigned-address bus error evaluator.
// Ignores the error entirely with exceptions disabled; otherwise always
// captures the address and records a cause only when that bus kind is enabled.
module exc_bus_chk
    import exc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ESR_W  = 32
) (
    input  logic              exc_en,
    input  logic              cfg_ibus_en,
    input  logic              cfg_dbus_en,
    input  logic              bus_err,
    input  logic              bus_fetch,
    input  logic [ADDR_W-1:0] bus_addr,
    output exc_ctl_t          ctl,
    output logic [ESR_W-1:0]  esr_val,
    output logic [ADDR_W-1:0] ear_val
);

    logic live;
    logic kind_en;

    // Select the enable of the faulting bus and build the claim.
    always_comb begin
        live       = bus_err && exc_en;
        kind_en    = bus_fetch ? cfg_ibus_en : cfg_dbus_en;
        ctl.touch  = live;
        ctl.ear_wr = live;
        ctl.esr_wr = live && kind_en;
        ctl.raise  = live && kind_en;
        esr_val    = bus_fetch ? ESR_W'(EC_IBUS) : ESR_W'(EC_DBUS);
        ear_val    = bus_addr;
    end

endmodule

// File: rtl/exc_prio_sel.sv
// Fixed-priority selector: index 0 ranks highest.
// Grants the first claiming source and forwards its control and values.
module exc_prio_sel
    import exc_pkg::*;
#(
    parameter int N      = 4,
    parameter int ESR_W  = 32,
    parameter int ADDR_W = 32
) (
    input  exc_ctl_t [N-1:0]             ctl_in,
    input  logic     [N-1:0][ESR_W-1:0]  esr_in,
    input  logic     [N-1:0][ADDR_W-1:0] ear_in,
    output exc_ctl_t                     win_ctl,
    output logic     [ESR_W-1:0]         win_esr,
    output logic     [ADDR_W-1:0]        win_ear
);

    logic [N-1:0] touch;
    logic [N-1:0] grant;

    for (genvar g = 0; g < N; g++) begin : g_touch
        assign touch[g] = ctl_in[g].touch;
        if (g == 0) begin : g_top
            assign grant[g] = touch[g];
        end else begin : g_rest
            assign grant[g] = touch[g] && !(|touch[g-1:0]);
        end
    end

    // AND-OR mux of the granted source.
    always_comb begin
        win_ctl = '0;
        win_esr = '0;
        win_ear = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) begin
                win_ctl = win_ctl | ctl_in[i];
                win_esr = win_esr | esr_in[i];
                win_ear = win_ear | ear_in[i];
            end
        end
    end

endmodule

// File: rtl/exc_cause_encoder.sv
// Exception cause encoder top.
// Evaluates four fault sources, ranks them (stack, alignment, divide, bus),
// and registers the winner into the status and address registers plus a
// one-cycle request. Assumes strobes are single-cycle per event.
module exc_cause_encoder
    import exc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int MASK_W = 2,
    parameter int REG_W  = 5,
    parameter int ESR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_en,
    input  logic              cfg_divz_mask,
    input  logic              cfg_ibus_en,
    input  logic              cfg_dbus_en,
    input  logic              div_valid,
    input  logic [DATA_W-1:0] div_divisor,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [MASK_W-1:0] acc_mask,
    input  logic              acc_write,
    input  logic [REG_W-1:0]  acc_dreg,
    input  logic              stk_valid,
    input  logic [ADDR_W-1:0] stk_addr,
    input  logic [ADDR_W-1:0] stk_low,
    input  logic [ADDR_W-1:0] stk_high,
    input  logic              bus_err,
    input  logic              bus_fetch,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              div_squash,
    output logic [ESR_W-1:0]  esr,
    output logic [ADDR_W-1:0] ear,
    output logic              msr_dz,
    output logic              exc_req
);

    localparam int NSRC = 4;
    localparam int P_STK = 0;
    localparam int P_AL  = 1;
    localparam int P_DIV = 2;
    localparam int P_BUS = 3;

    exc_ctl_t [NSRC-1:0]             src_ctl;
    logic     [NSRC-1:0][ESR_W-1:0]  src_esr;
    logic     [NSRC-1:0][ADDR_W-1:0] src_ear;
    exc_ctl_t                        win_ctl;
    logic     [ESR_W-1:0]            win_esr;
    logic     [ADDR_W-1:0]           win_ear;

    exc_div_chk #(.DATA_W(DATA_W), .ESR_W(ESR_W)) u_div (
        .clk(clk), .rst_n(rst_n), .div_valid(div_valid), .divisor(div_divisor),
        .exc_en(exc_en), .cfg_divz_mask(cfg_divz_mask), .squash(div_squash),
        .msr_dz(msr_dz), .ctl(src_ctl[P_DIV]), .esr_val(src_esr[P_DIV])
    );
    assign src_ear[P_DIV] = '0;

    exc_mem_chk #(.ADDR_W(ADDR_W), .MASK_W(MASK_W), .REG_W(REG_W), .ESR_W(ESR_W)) u_mem (
        .exc_en(exc_en), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_mask(acc_mask), .acc_write(acc_write), .acc_dreg(acc_dreg),
        .stk_valid(stk_valid), .stk_addr(stk_addr), .stk_low(stk_low),
        .stk_high(stk_high),
        .al_ctl(src_ctl[P_AL]), .al_esr(src_esr[P_AL]), .al_ear(src_ear[P_AL]),
        .st_ctl(src_ctl[P_STK]), .st_esr(src_esr[P_STK]), .st_ear(src_ear[P_STK])
    );

    exc_bus_chk #(.ADDR_W(ADDR_W), .ESR_W(ESR_W)) u_bus (
        .exc_en(exc_en), .cfg_ibus_en(cfg_ibus_en), .cfg_dbus_en(cfg_dbus_en),
        .bus_err(bus_err), .bus_fetch(bus_fetch), .bus_addr(bus_addr),
        .ctl(src_ctl[P_BUS]), .esr_val(src_esr[P_BUS]), .ear_val(src_ear[P_BUS])
    );

    exc_prio_sel #(.N(NSRC), .ESR_W(ESR_W), .ADDR_W(ADDR_W)) u_sel (
        .ctl_in(src_ctl), .esr_in(src_esr), .ear_in(src_ear),
        .win_ctl(win_ctl), .win_esr(win_esr), .win_ear(win_ear)
    );

    // Register the winning source into the architectural state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            esr     <= '0;
            ear     <= '0;
            exc_req <= 1'b0;
        end else begin
            exc_req <= win_ctl.raise;
            if (win_ctl.esr_wr) esr <= win_esr;
            if (win_ctl.ear_wr) ear <= win_ear;
        end
    end

    logic any_strobe;
    assign any_strobe = div_valid || acc_valid || stk_valid || bus_err;

    assert_stack_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_valid && ((stk_addr < stk_low) || (stk_addr > stk_high)))
        |=> (exc_req && ear == $past(stk_addr)));

    assert_req_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> $past(any_strobe));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !any_strobe |=> ($stable(esr) && $stable(ear) && !exc_req));

    assert_bus_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && !exc_en && !div_valid && !acc_valid && !stk_valid)
        |=> ($stable(esr) && $stable(ear) && !exc_req));

endmodule

// File: tb/sim_exc_cause_encoder.sv
`timescale 1ns/100ps
module sim_exc_cause_encoder;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        exc_en, cfg_divz_mask, cfg_ibus_en, cfg_dbus_en;
    logic        div_valid;
    logic [31:0] div_divisor;
    logic        acc_valid;
    logic [31:0] acc_addr;
    logic [1:0]  acc_mask;
    logic        acc_write;
    logic [4:0]  acc_dreg;
    logic        stk_valid;
    logic [31:0] stk_addr, stk_low, stk_high;
    logic        bus_err, bus_fetch;
    logic [31:0] bus_addr;
    logic        div_squash, msr_dz, exc_req;
    logic [31:0] esr, ear;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    exc_cause_encoder u0 (.*);

    // Vector: src 0=div 1=align 2=stack 3=bus
    typedef struct packed {
        logic [1:0]  src;
        logic        ee;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] c;
        logic        f;
        logic [4:0]  dreg;
        logic [31:0] x_esr;
        logic [31:0] x_ear;
        logic        x_req;
        logic        x_dz;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b1, 32'h0,    32'h0,   32'h0,   1'b0, 5'd0,  32'h5,   32'h0,    1'b1, 1'b1},
        '{2'd0, 1'b1, 32'h7,    32'h0,   32'h0,   1'b0, 5'd0,  32'h5,   32'h0,    1'b0, 1'b0},
        '{2'd1, 1'b0, 32'h1002, 32'h3,   32'h0,   1'b1, 5'd9,  32'hD21, 32'h1002, 1'b0, 1'b0},
        '{2'd1, 1'b1, 32'h2001, 32'h1,   32'h0,   1'b0, 5'd31, 32'h3E1, 32'h2001, 1'b1, 1'b0},
        '{2'd1, 1'b1, 32'h3004, 32'h3,   32'h0,   1'b1, 5'd3,  32'h3E1, 32'h2001, 1'b0, 1'b0},
        '{2'd2, 1'b0, 32'hFF,   32'h100, 32'h200, 1'b0, 5'd0,  32'h7,   32'hFF,   1'b1, 1'b0},
        '{2'd2, 1'b1, 32'h200,  32'h100, 32'h200, 1'b0, 5'd0,  32'h7,   32'hFF,   1'b0, 1'b0},
        '{2'd2, 1'b1, 32'h201,  32'h100, 32'h200, 1'b0, 5'd0,  32'h7,   32'h201,  1'b1, 1'b0},
        '{2'd3, 1'b1, 32'hA000, 32'h0,   32'h0,   1'b1, 5'd0,  32'h3,   32'hA000, 1'b1, 1'b0},
        '{2'd3, 1'b1, 32'hB000, 32'h0,   32'h0,   1'b0, 5'd0,  32'h4,   32'hB000, 1'b1, 1'b0},
        '{2'd3, 1'b0, 32'hC000, 32'h0,   32'h0,   1'b1, 5'd0,  32'h4,   32'hB000, 1'b0, 1'b0},
        '{2'd0, 1'b0, 32'h0,    32'h0,   32'h0,   1'b0, 5'd0,  32'h4,   32'hB000, 1'b0, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        div_valid = 0; acc_valid = 0; stk_valid = 0; bus_err = 0;
    endtask

    // Outputs checked one edge after the strobe, at the following negedge.
    task automatic expect_state(input string tag, input logic [31:0] x_esr,
                                input logic [31:0] x_ear, input logic x_req, input logic x_dz);
        @(negedge clk);
        idle();
        chk({tag, " esr"}, esr, x_esr);
        chk({tag, " ear"}, ear, x_ear);
        chk({tag, " req"}, {31'b0, exc_req}, {31'b0, x_req});
        chk({tag, " dz"},  {31'b0, msr_dz},  {31'b0, x_dz});
    endtask

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0; exc_en = 1; cfg_divz_mask = 0; cfg_ibus_en = 1; cfg_dbus_en = 1;
        idle();
        div_divisor = 0; acc_addr = 0; acc_mask = 0; acc_write = 0; acc_dreg = 0;
        stk_addr = 0; stk_low = 0; stk_high = 32'hFFFF_FFFF; bus_fetch = 0; bus_addr = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 esr", esr, 0);
        chk("R1 ear", ear, 0);
        chk("R1 dz req", {30'b0, msr_dz, exc_req}, 0);
        rst_n = 1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            exc_en = VECS[i].ee;
            case (VECS[i].src)
                2'd0: begin div_valid = 1; div_divisor = VECS[i].a; end
                2'd1: begin acc_valid = 1; acc_addr = VECS[i].a; acc_mask = VECS[i].b[1:0];
                            acc_write = VECS[i].f; acc_dreg = VECS[i].dreg; end
                2'd2: begin stk_valid = 1; stk_addr = VECS[i].a; stk_low = VECS[i].b;
                            stk_high = VECS[i].c; end
                default: begin bus_err = 1; bus_addr = VECS[i].a; bus_fetch = VECS[i].f; end
            endcase
            #1;
            if (VECS[i].src == 2'd0)
                chk($sformatf("R2 squash v%0d", i), {31'b0, div_squash}, {31'b0, (VECS[i].a == 0)});
            expect_state($sformatf("R3 R4 R5 R6 R7 v%0d", i),
                         VECS[i].x_esr, VECS[i].x_ear, VECS[i].x_req, VECS[i].x_dz);
        end

        // R9: request lasts one cycle, state held while idle
        @(negedge clk);
        chk("R9 req low", {31'b0, exc_req}, 0);
        chk("R9 esr hold", esr, 32'h4);

        // R3: masked divide by zero only sets the flag
        exc_en = 1; cfg_divz_mask = 1; div_valid = 1; div_divisor = 0;
        expect_state("R3 masked", 32'h4, 32'hB000, 1'b0, 1'b1);
        cfg_divz_mask = 0;

        // R7: bus kind disabled keeps cause but captures the address
        @(negedge clk);
        cfg_ibus_en = 0; bus_err = 1; bus_fetch = 1; bus_addr = 32'hD000;
        expect_state("R7 ibus off", 32'h4, 32'hD000, 1'b0, 1'b1);
        cfg_ibus_en = 1;

        // R8: all four together, stack wins
        @(negedge clk);
        div_valid = 1; div_divisor = 0;
        acc_valid = 1; acc_addr = 32'h11; acc_mask = 2'd3; acc_write = 0; acc_dreg = 5'd2;
        stk_valid = 1; stk_addr = 32'h50; stk_low = 32'h100; stk_high = 32'h200;
        bus_err = 1; bus_fetch = 0; bus_addr = 32'hE000;
        expect_state("R8 all four", 32'h7, 32'h50, 1'b1, 1'b1);
        @(negedge clk);
        chk("R9 after burst", {31'b0, exc_req}, 0);

        // R8: alignment beats divide and bus
        div_valid = 1; div_divisor = 0;
        acc_valid = 1; acc_addr = 32'h13; acc_mask = 2'd1; acc_write = 1; acc_dreg = 5'd4;
        bus_err = 1; bus_fetch = 0; bus_addr = 32'hE000;
        expect_state("R8 align wins", 32'h481, 32'h13, 1'b1, 1'b1);

        // R8: divide beats bus, address register untouched
        @(negedge clk);
        div_valid = 1; div_divisor = 0;
        bus_err = 1; bus_fetch = 1; bus_addr = 32'hF000;
        expect_state("R8 div over bus", 32'h5, 32'h13, 1'b1, 1'b1);

        // R1: reset in mid-run
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        chk("R1 re-reset esr", esr, 0);
        chk("R1 re-reset ear", ear, 0);
        chk("R1 re-reset dz", {31'b0, msr_dz}, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule